// File: doc/BRIEF.md
# Palette Attribute Port Controller

This block holds the colour attribute registers of a planar display adapter and performs the final per-pixel colour translation. A host reaches every register through one write port. An internal phase bit decides whether a byte written there is a register selector or a data value. After each accepted write the phase flips. A read of the adapter's input-status port forces the phase back to selector.

The selector byte also carries an access bit. When that bit is high, the screen is driven and the sixteen palette entries are locked. When it is low, the output is dark and the palette may be reprogrammed.

On the pixel side, a 4-bit colour code from the plane serializer is masked by the plane-enable bits and used to pick one of sixteen 6-bit palette colours. The result is registered, so it appears one clock later. During the border region the overscan colour is sent instead of the palette colour. Two of the six output colour lines are also brought out for a status register, and the plane-enable register chooses which pair.

Top module: `pal_attr_ctrl`

## Requirements
- R1: After reset the port is in selector phase. Each accepted write flips the phase, so selector and data writes alternate.
- R2: A pulse on `stat_rd` returns the port to selector phase. A write presented in the same cycle as `stat_rd` is discarded and changes no register.
- R3: Selector bits 4:0 choose the target register: values 0 to 15 are palette entries, 16 is mode control (4 bits), 17 is overscan (6 bits), 18 is plane enable (6 bits) and 19 is pixel panning (4 bits). Data bits above a register's width are dropped. A data write to selector values 20 to 31 changes nothing, but it still flips the phase.
- R4: Selector bit 5 is held as the access bit and drives `out_enable`. While it is 1, data writes to palette entries are discarded, and writes to registers 16 to 19 still take effect.
- R5: While `out_enable` is 1 and `blank` is 0, `color_out` equals the palette entry indexed by `pix_in` AND plane-enable bits 3:0. The lookup uses the pixel presented one clock earlier.
- R6: While `out_enable` is 1 and `blank` is 1, `color_out` equals the overscan register one clock later.
- R7: While `out_enable` is 0, `color_out` is 0 one clock later, whatever the value of `blank`.
- R8: `stat_pair` reports two bits of `color_out` as {bit5, bit4} of the status byte. Colour bit order is 0 blue, 1 green, 2 red, 3 secondary blue, 4 secondary green, 5 secondary red. Plane-enable bits 5:4 choose the pair: 0 gives {red, blue}, 1 gives {green, secondary blue}, 2 gives {secondary green, secondary red}, and 3 gives {0, 0}.
- R9: Reset clears every register, the access bit and `color_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel and host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Write strobe for the shared selector/data port |
| host_wdata | input | 8 | Byte written to the shared port |
| stat_rd | input | 1 | Read strobe of the input-status port |
| pix_in | input | 4 | Colour code from the plane serializer |
| blank | input | 1 | High during the border region |
| color_out | output | 6 | Registered colour to the display |
| stat_pair | output | 2 | Selected colour pair for status bits 5:4 |
| out_enable | output | 1 | Access bit: screen driven, palette locked |
| mode_bits | output | 4 | Mode control register |
| pan_shift | output | 4 | Pixel panning register |

## Verification
A phase bit that is out of step makes every later byte land in the wrong role. A data value is then taken as a selector, and the symptom appears at `mode_bits`, `pan_shift` or `color_out` on the very next write pair. A stale access bit shows up in two ways: `color_out` is dark one clock after any pixel, or a palette entry that should be locked has been overwritten, which shows on the next lookup of that code. A wrong plane mask or pair selection appears at `color_out` or `stat_pair` in the cycle after the pixel is presented.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int HOST_W  = 8;
  localparam int IDX_W   = 5;
  localparam int PIX_W   = 4;
  localparam int COLOR_W = 6;
  localparam int NUM_PAL = 1 << PIX_W;

  localparam logic [IDX_W-1:0] SEL_MODE  = IDX_W'(NUM_PAL);
  localparam logic [IDX_W-1:0] SEL_OVS   = IDX_W'(NUM_PAL + 1);
  localparam logic [IDX_W-1:0] SEL_PLANE = IDX_W'(NUM_PAL + 2);
  localparam logic [IDX_W-1:0] SEL_PAN   = IDX_W'(NUM_PAL + 3);

  typedef enum logic [1:0] {
    PAIR_RB   = 2'd0,
    PAIR_GSB  = 2'd1,
    PAIR_SGSR = 2'd2,
    PAIR_NONE = 2'd3
  } pair_sel_e;
endpackage

// File: rtl/attr_port_seq.sv
module attr_port_seq #(
  parameter int HOST_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [HOST_W-1:0] wdata,
  input  logic              stat_rd,
  output logic              data_we,
  output logic [IDX_W-1:0]  idx,
  output logic              out_en
);
  logic             phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en_q, en_d;
  logic             accept, sel_load;

  logic unused_hi;
  assign unused_hi = ^wdata[HOST_W-1:IDX_W+1];

  always_comb begin
    accept   = wr && !stat_rd;
    sel_load = accept && !phase_q;
    data_we  = accept && phase_q;
    phase_d  = phase_q;
    if (stat_rd)     phase_d = 1'b0;
    else if (accept) phase_d = !phase_q;
    idx_d = idx_q;
    en_d  = en_q;
    if (sel_load) begin
      idx_d = wdata[IDX_W-1:0];
      en_d  = wdata[IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      idx_q   <= '0;
      en_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
      en_q    <= en_d;
    end
  end

  assign idx    = idx_q;
  assign out_en = en_q;

  assert_phase_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !stat_rd) |=> (phase_q != $past(phase_q)));
  assert_status_rewind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !phase_q);
  assert_status_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ($stable(idx_q) && $stable(en_q)));
endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pkg::*;
#(
  parameter int NPAL = 16,
  parameter int CW   = 6,
  parameter int IW   = 5,
  parameter int HW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_we,
  input  logic [IW-1:0]            idx,
  input  logic                     out_en,
  input  logic [HW-1:0]            wdata,
  output logic [NPAL-1:0][CW-1:0]  pal,
  output logic [3:0]               mode,
  output logic [CW-1:0]            ovs,
  output logic [5:0]               plane,
  output logic [3:0]               pan
);
  logic [NPAL-1:0][CW-1:0] pal_q, pal_d;
  logic [3:0]    mode_q, mode_d, pan_q, pan_d;
  logic [CW-1:0] ovs_q, ovs_d;
  logic [5:0]    plane_q, plane_d;

  for (genvar g = 0; g < NPAL; g++) begin : g_entry
    logic hit;
    always_comb begin
      hit      = data_we && !out_en && (idx == IW'(g));
      pal_d[g] = hit ? wdata[CW-1:0] : pal_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pal_q[g] <= '0;
      else        pal_q[g] <= pal_d[g];
    end
  end

  always_comb begin
    mode_d  = mode_q;
    ovs_d   = ovs_q;
    plane_d = plane_q;
    pan_d   = pan_q;
    if (data_we) begin
      case (idx)
        SEL_MODE:  mode_d  = wdata[3:0];
        SEL_OVS:   ovs_d   = wdata[CW-1:0];
        SEL_PLANE: plane_d = wdata[5:0];
        SEL_PAN:   pan_d   = wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      ovs_q   <= '0;
      plane_q <= '0;
      pan_q   <= '0;
    end else begin
      mode_q  <= mode_d;
      ovs_q   <= ovs_d;
      plane_q <= plane_d;
      pan_q   <= pan_d;
    end
  end

  assign pal   = pal_q;
  assign mode  = mode_q;
  assign ovs   = ovs_q;
  assign plane = plane_q;
  assign pan   = pan_q;

  assert_palette_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |=> $stable(pal_q));
  assert_unused_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx > SEL_PAN) |=>
      ($stable(pal_q) && $stable(mode_q) && $stable(ovs_q) && $stable(plane_q) && $stable(pan_q)));
endmodule

// File: rtl/attr_color_pipe.sv
module attr_color_pipe
  import attr_pkg::*;
#(
  parameter int PW   = 4,
  parameter int CW   = 6,
  parameter int NPAL = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PW-1:0]           pix,
  input  logic                    blank,
  input  logic                    out_en,
  input  logic [NPAL-1:0][CW-1:0] pal,
  input  logic [5:0]              plane,
  input  logic [CW-1:0]           ovs,
  output logic [CW-1:0]           color,
  output logic [1:0]              pair
);
  logic [CW-1:0] color_q, color_d;
  logic [PW-1:0] code;
  pair_sel_e     psel;

  always_comb begin
    code = pix & plane[PW-1:0];
    if (!out_en)    color_d = '0;
    else if (blank) color_d = ovs;
    else            color_d = pal[code];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) color_q <= '0;
    else        color_q <= color_d;
  end

  always_comb begin
    psel = pair_sel_e'(plane[5:4]);
    case (psel)
      PAIR_RB:   pair = {color_q[2], color_q[0]};
      PAIR_GSB:  pair = {color_q[1], color_q[3]};
      PAIR_SGSR: pair = {color_q[4], color_q[5]};
      default:   pair = 2'b00;
    endcase
  end

  assign color = color_q;

  assert_dark_when_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |=> (color_q == '0));
  assert_border_colour_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && blank) |=> (color_q == $past(ovs)));
endmodule

// File: rtl/pal_attr_ctrl.sv
module pal_attr_ctrl
  import attr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_W-1:0]  host_wdata,
  input  logic               stat_rd,
  input  logic [PIX_W-1:0]   pix_in,
  input  logic               blank,
  output logic [COLOR_W-1:0] color_out,
  output logic [1:0]         stat_pair,
  output logic               out_enable,
  output logic [3:0]         mode_bits,
  output logic [3:0]         pan_shift
);
  logic                          data_we;
  logic [IDX_W-1:0]              idx;
  logic                          en;
  logic [NUM_PAL-1:0][COLOR_W-1:0] pal;
  logic [COLOR_W-1:0]            ovs;
  logic [5:0]                    plane;

  attr_port_seq #(.HOST_W(HOST_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
    .stat_rd(stat_rd), .data_we(data_we), .idx(idx), .out_en(en)
  );

  attr_regs #(.NPAL(NUM_PAL), .CW(COLOR_W), .IW(IDX_W), .HW(HOST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_we(data_we), .idx(idx), .out_en(en),
    .wdata(host_wdata), .pal(pal), .mode(mode_bits), .ovs(ovs),
    .plane(plane), .pan(pan_shift)
  );

  attr_color_pipe #(.PW(PIX_W), .CW(COLOR_W), .NPAL(NUM_PAL)) u_pipe (
    .clk(clk), .rst_n(rst_n), .pix(pix_in), .blank(blank), .out_en(en),
    .pal(pal), .plane(plane), .ovs(ovs), .color(color_out), .pair(stat_pair)
  );

  assign out_enable = en;
endmodule

// File: tb/pal_attr_ctrl_test.sv
module pal_attr_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_wr;
  logic [7:0] host_wdata;
  logic       stat_rd;
  logic [3:0] pix_in;
  logic       blank;
  logic [5:0] color_out;
  logic [1:0] stat_pair;
  logic       out_enable;
  logic [3:0] mode_bits, pan_shift;

  int checks = 0;
  int fails  = 0;

  always #4 clk = !clk;

  pal_attr_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .stat_rd(stat_rd), .pix_in(pix_in), .blank(blank), .color_out(color_out),
    .stat_pair(stat_pair), .out_enable(out_enable), .mode_bits(mode_bits),
    .pan_shift(pan_shift)
  );

  function automatic logic [5:0] pal_val(int i);
    return 6'((i * 5 + 3) & 63);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] v);
    @(negedge clk);
    host_wr = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic see(logic [3:0] p, logic b, logic [5:0] exp, string req);
    @(negedge clk);
    pix_in = p; blank = b;
    @(negedge clk);
    check(req, color_out, exp);
  endtask

  task automatic t_reset;
    check("R9 colour", color_out, 0);
    check("R9 access", out_enable, 0);
    check("R9 mode", mode_bits, 0);
    check("R9 pan", pan_shift, 0);
    check("R9 pair", stat_pair, 0);
  endtask

  task automatic t_palette;
    for (int i = 0; i < 16; i++) begin
      put(8'(i));
      put({2'b00, pal_val(i)});
    end
    put(8'h32); put(8'h0F);
    check("R4 access set", out_enable, 1);
    for (int i = 0; i < 16; i++) see(4'(i), 1'b0, pal_val(i), "R5 lookup");
  endtask

  task automatic t_lock;
    put(8'h21); put(8'h3F);
    see(4'd1, 1'b0, pal_val(1), "R4 palette locked");
    put(8'h30); put(8'hFB);
    check("R4 R3 mode while locked", mode_bits, 4'hB);
    put(8'h33); put(8'hF7);
    check("R3 pan width", pan_shift, 7);
  endtask

  task automatic t_unused;
    put(8'h34); put(8'h05);
    check("R3 unused sel mode", mode_bits, 4'hB);
    check("R3 unused sel pan", pan_shift, 7);
    put(8'h33); put(8'h02);
    check("R1 phase after unused", pan_shift, 2);
  endtask

  task automatic t_status_rewind;
    put(8'h01);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    put(8'h33); put(8'h04);
    check("R2 rewind pan", pan_shift, 4);
    see(4'd1, 1'b0, pal_val(1), "R2 palette untouched");
  endtask

  task automatic t_collide;
    put(8'h33);
    @(negedge clk); host_wr = 1'b1; host_wdata = 8'h09; stat_rd = 1'b1;
    @(negedge clk); host_wr = 1'b0; stat_rd = 1'b0;
    check("R2 colliding write dropped", pan_shift, 4);
    put(8'h33); put(8'h06);
    check("R2 selector after collision", pan_shift, 6);
  endtask

  task automatic t_mask;
    put(8'h32); put(8'h05);
    see(4'hF, 1'b0, pal_val(5), "R5 plane mask F");
    see(4'hA, 1'b0, pal_val(0), "R5 plane mask A");
  endtask

  task automatic t_border;
    put(8'h31); put(8'h2A);
    see(4'd3, 1'b1, 6'h2A, "R6 border");
    see(4'd3, 1'b0, pal_val(1), "R6 leave border");
  endtask

  task automatic t_pairs;
    put(8'h02); put(8'h1D);
    check("R4 access clear", out_enable, 0);
    see(4'd2, 1'b1, 6'h00, "R7 dark blank");
    see(4'd2, 1'b0, 6'h00, "R7 dark pixel");
    put(8'h32); put(8'h0F);
    see(4'd2, 1'b0, 6'h1D, "R5 new entry");
    check("R8 pair 0", stat_pair, 2'b11);
    put(8'h32); put(8'h1F);
    check("R8 pair 1", stat_pair, 2'b01);
    put(8'h32); put(8'h2F);
    check("R8 pair 2", stat_pair, 2'b10);
    put(8'h32); put(8'h3F);
    check("R8 pair 3", stat_pair, 2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = '0; stat_rd = 1'b0;
    pix_in = '0; blank = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_palette;
    t_lock;
    t_unused;
    t_status_rewind;
    t_collide;
    t_mask;
    t_border;
    t_pairs;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule